// File: doc/BRIEF.md
# Boot-Time Register Image Loader

After reset the loader becomes bus master on a two-wire serial bus and pulls a configuration image out of an attached serial memory in one continuous burst read that starts at memory address 0. The byte-level bus engine sits outside this block and is reached through a byte-read handshake. The loader breaks the incoming byte stream into blocks of 32-bit register writes and drives each write onto an internal register-write port as soon as its last byte arrives.

A 16-bit check value at the end of the image is compared with a CRC that the loader builds from every earlier byte. An input can bypass that comparison. When the image has been read, or a read has failed, the loader hands the bus back to slave mode. It then shows success or failure on two status outputs. Those outputs keep their value until a new load is started.

A fixed clock divisor spaces out the byte requests, so that the request rate follows the serial bus timing. While the loader holds the bus, the slave address-select pin has no effect.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, and straight after it, the loader is busy and master. It requests the first byte with rdFirst high and rdAddr = 0x0000, and doneOk and doneFail are both low.
- R2: Image layout, every multi-byte field most significant byte first. The image opens with a 2-byte block count. Each block holds a 1-byte register count, then a 3-byte word address (the byte address divided by four), then 4 data bytes for each register. A 2-byte check value closes the image.
- R3: Each register produces one single-cycle wrEn pulse carrying the 32-bit data. The first register of a block goes to the block's word address and each later one to the next word address up.
- R4: A block count of zero is accepted, and so is a block whose register count is zero. Either way the image goes on to the next field with no write.
- R5: The CRC starts at 0xFFFF and uses polynomial 0x1021. Each byte is fed in most significant bit first, and the feedback is crc[15] XOR the input bit. The stored value is the final CRC with its bit order reversed (bit i goes to bit 15-i). A match sets doneOk.
- R6: A CRC mismatch sets doneFail. Writes already issued from the image stay issued.
- R7: With cfgSkipCrc high, the check bytes are still read but never compared, and the load ends with doneOk.
- R8: A missing acknowledge (rdNack) during a byte request aborts the load with doneFail. No further byte is requested and no further write is made.
- R9: rdLast is high exactly on the request for the final check byte, and a full load reads exactly the image length in bytes.
- R10: A new byte request rises exactly CLK_DIV+1 cycles after the cycle in which rdValid was presented (CLK_DIV resets to 0x62).
- R11: masterMode equals busy. slvAddrSel is 0 while busy and follows addrSelIn while idle.
- R12: doneOk and doneFail hold until loadStart is pulsed while idle, and that pulse clears both. A loadStart pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; a load begins on release |
| loadStart | input | 1 | Starts a new load when idle |
| cfgSkipCrc | input | 1 | Bypass the check-value comparison |
| addrSelIn | input | 1 | External slave address-select pin |
| slvAddrSel | output | 1 | Address select as seen by slave decoding |
| masterMode | output | 1 | Loader owns the serial bus |
| rdReq | output | 1 | Byte request to the bus engine |
| rdFirst | output | 1 | Request opens the burst at rdAddr |
| rdLast | output | 1 | Request is the final byte of the burst |
| rdAddr | output | 16 | Burst start address in the serial memory |
| rdValid | input | 1 | Requested byte is on rdData |
| rdData | input | 8 | Byte returned by the bus engine |
| rdNack | input | 1 | Memory failed to acknowledge |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 24 | Register word address |
| wrData | output | 32 | Register write data |
| busy | output | 1 | Read in progress |
| doneOk | output | 1 | Last load completed successfully |
| doneFail | output | 1 | Last load failed |

## Verification
The hardest case to reach from the ports is an abort partway through a data word. The bench model raises rdNack at a chosen byte index, a few bytes into the second register. The expected write list is cut at the last register whose fourth byte came before that index. Blocks with no registers, and a zero block count, are built into their own images so that the field sequencer skips the address-to-data step. A loadStart pulse is also sent in the middle of a load, and it must not bring rdFirst back.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {F_BCNT, F_RCNT, F_ADDR, F_DATA, F_CRC} fld_e;

  typedef struct packed {
    logic clr;
    logic take;
    logic crcOn;
    fld_e fld;
  } dpCtl_t;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [7:0]              byteIn,
  output logic                    atBound,
  output logic                    blkZero,
  output logic                    regZero,
  output logic                    crcOk,
  output logic                    wrEn,
  output logic [ADDR_BYTES*8-1:0] wrAddr,
  output logic [DATA_BYTES*8-1:0] wrData
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int DW = DATA_BYTES * 8;
  localparam int IW = $clog2(DATA_BYTES + 1) + 1;

  logic [IW-1:0] byteIdx;
  logic [DW-1:0] asmReg, asmNext;
  logic [15:0]   blkLeft, crcAcc, crcRx, crcRev;
  logic [7:0]    regLeft;
  logic [AW-1:0] wordAddr;
  logic          lastB;

  function automatic int fieldLen(input fld_e f);
    case (f)
      F_BCNT:  return 2;
      F_RCNT:  return 1;
      F_ADDR:  return ADDR_BYTES;
      F_DATA:  return DATA_BYTES;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  assign asmNext = {asmReg[DW-9:0], byteIn};
  assign lastB   = (byteIdx == IW'(fieldLen(ctl.fld) - 1));
  assign atBound = (byteIdx == '0);
  assign blkZero = (blkLeft == '0);
  assign regZero = (regLeft == '0);

  always_comb begin
    for (int i = 0; i < 16; i++) crcRev[i] = crcAcc[15-i];
  end
  assign crcOk = (crcRx == crcRev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx  <= '0;
      asmReg   <= '0;
      blkLeft  <= '0;
      regLeft  <= '0;
      wordAddr <= '0;
      crcAcc   <= CRC_INIT;
      crcRx    <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrEn <= 1'b0;
      if (ctl.clr) begin
        byteIdx  <= '0;
        blkLeft  <= '0;
        regLeft  <= '0;
        wordAddr <= '0;
        crcAcc   <= CRC_INIT;
        crcRx    <= '0;
      end else if (ctl.take) begin
        asmReg  <= asmNext;
        byteIdx <= lastB ? '0 : byteIdx + 1'b1;
        if (ctl.crcOn) crcAcc <= crcStep(crcAcc, byteIn);
        if (lastB) begin
          case (ctl.fld)
            F_BCNT: blkLeft <= asmNext[15:0];
            F_RCNT: begin
              regLeft <= byteIn;
              blkLeft <= blkLeft - 16'd1;
            end
            F_ADDR: wordAddr <= asmNext[AW-1:0];
            F_DATA: begin
              wrEn     <= 1'b1;
              wrAddr   <= wordAddr;
              wrData   <= asmNext;
              wordAddr <= wordAddr + 1'b1;
              regLeft  <= regLeft - 8'd1;
            end
            default: crcRx <= asmNext[15:0];
          endcase
        end
      end
    end
  end

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) wrEn |=> !wrEn);
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int CLK_DIV = 8'h62
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   loadStart,
  input  logic   cfgSkipCrc,
  input  logic   rdValid,
  input  logic   rdNack,
  input  logic   atBound,
  input  logic   blkZero,
  input  logic   regZero,
  input  logic   crcOk,
  output dpCtl_t ctl,
  output logic   rdReq,
  output logic   rdFirst,
  output logic   rdLast,
  output logic   busy,
  output logic   doneOk,
  output logic   doneFail
);
  localparam int GW = $clog2(CLK_DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP, S_FIN} st_e;
  st_e           state;
  fld_e          fld;
  logic [GW-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_REQ;
      fld      <= F_BCNT;
      gapCnt   <= '0;
      doneOk   <= 1'b0;
      doneFail <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (loadStart) begin
          state    <= S_REQ;
          fld      <= F_BCNT;
          doneOk   <= 1'b0;
          doneFail <= 1'b0;
        end
        S_REQ: begin
          if (rdNack) begin
            state    <= S_IDLE;
            doneFail <= 1'b1;
          end else if (rdValid) begin
            state  <= S_GAP;
            gapCnt <= GW'(CLK_DIV - 1);
          end
        end
        S_GAP: begin
          if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
          else if (!atBound) state <= S_REQ;
          else begin
            state <= S_REQ;
            case (fld)
              F_BCNT: fld <= blkZero ? F_CRC : F_RCNT;
              F_RCNT: fld <= F_ADDR;
              F_ADDR, F_DATA: fld <= !regZero ? F_DATA : (blkZero ? F_CRC : F_RCNT);
              default: state <= S_FIN;
            endcase
          end
        end
        default: begin
          state <= S_IDLE;
          if (cfgSkipCrc || crcOk) doneOk <= 1'b1;
          else doneFail <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl.clr   = (state == S_IDLE) && loadStart;
    ctl.take  = (state == S_REQ) && rdValid && !rdNack;
    ctl.crcOn = (fld != F_CRC);
    ctl.fld   = fld;
  end

  assign rdReq   = (state == S_REQ);
  assign rdFirst = rdReq && (fld == F_BCNT) && atBound;
  assign rdLast  = rdReq && (fld == F_CRC) && !atBound;
  assign busy    = (state != S_IDLE);

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0({doneOk, doneFail}));
  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !loadStart) |=> ($stable(doneOk) && $stable(doneFail)));
  // R8
  nack_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REQ && rdNack) |=> (doneFail && !busy));
  // R9
  last_first_chk: assert property (@(posedge clk) disable iff (!rstN) rdLast |-> !rdFirst);
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfgld_pkg::*;
#(
  parameter int          CLK_DIV    = 8'h62,
  parameter int          ADDR_BYTES = 3,
  parameter int          DATA_BYTES = 4,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadStart,
  input  logic                    cfgSkipCrc,
  input  logic                    addrSelIn,
  output logic                    slvAddrSel,
  output logic                    masterMode,
  output logic                    rdReq,
  output logic                    rdFirst,
  output logic                    rdLast,
  output logic [15:0]             rdAddr,
  input  logic                    rdValid,
  input  logic [7:0]              rdData,
  input  logic                    rdNack,
  output logic                    wrEn,
  output logic [ADDR_BYTES*8-1:0] wrAddr,
  output logic [DATA_BYTES*8-1:0] wrData,
  output logic                    busy,
  output logic                    doneOk,
  output logic                    doneFail
);
  dpCtl_t ctl;
  logic   atBound, blkZero, regZero, crcOk;

  cfgld_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .cfgSkipCrc(cfgSkipCrc),
    .rdValid(rdValid), .rdNack(rdNack), .atBound(atBound), .blkZero(blkZero),
    .regZero(regZero), .crcOk(crcOk), .ctl(ctl), .rdReq(rdReq), .rdFirst(rdFirst),
    .rdLast(rdLast), .busy(busy), .doneOk(doneOk), .doneFail(doneFail)
  );

  cfgld_dp #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteIn(rdData), .atBound(atBound),
    .blkZero(blkZero), .regZero(regZero), .crcOk(crcOk), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  assign rdAddr     = START_ADDR;
  assign masterMode = busy;
  assign slvAddrSel = busy ? 1'b0 : addrSelIn;
endmodule

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb_top;
  localparam int DIV = 98;

  logic clk = 1'b0, rstN = 1'b0;
  logic loadStart = 1'b0, cfgSkipCrc = 1'b0, addrSelIn = 1'b0;
  logic rdValid = 1'b0, rdNack = 1'b0;
  logic [7:0] rdData = '0;
  logic slvAddrSel, masterMode, rdReq, rdFirst, rdLast, wrEn, busy, doneOk, doneFail;
  logic [15:0] rdAddr;
  logic [23:0] wrAddr;
  logic [31:0] wrData;

  always #5 clk = ~clk;

  cfg_eeprom_loader dut_i (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .cfgSkipCrc(cfgSkipCrc),
    .addrSelIn(addrSelIn), .slvAddrSel(slvAddrSel), .masterMode(masterMode),
    .rdReq(rdReq), .rdFirst(rdFirst), .rdLast(rdLast), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .rdNack(rdNack), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .doneOk(doneOk), .doneFail(doneFail)
  );

  byte unsigned img[$];
  int          expA[$];
  int unsigned expD[$];
  int          expI[$];
  int nackIdx = -1, ptr = 0, lat = 0, latSet = 2;
  int vec = 0, bad = 0, cyc = 0, serveCyc = 0;
  bit waitGap = 1'b0;

  task automatic chk(string req, string what, longint act, longint exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int crcImg();
    int c = 'hFFFF;
    int r = 0;
    foreach (img[k])
      for (int b = 7; b >= 0; b--) begin
        int fb = ((c >> 15) & 1) ^ ((img[k] >> b) & 1);
        c = (c << 1) & 'hFFFF;
        if (fb != 0) c = c ^ 'h1021;
      end
    for (int i = 0; i < 16; i++) if (((c >> i) & 1) != 0) r = r | (1 << (15 - i));
    return r;
  endfunction

  task automatic newImg(int nblk);
    img.delete(); expA.delete(); expD.delete(); expI.delete();
    img.push_back(8'(nblk >> 8)); img.push_back(8'(nblk));
  endtask

  task automatic addBlk(int wa, int n, int seed);
    img.push_back(8'(n));
    img.push_back(8'(wa >> 16)); img.push_back(8'(wa >> 8)); img.push_back(8'(wa));
    for (int r = 0; r < n; r++) begin
      int unsigned d = (32'h9E3779B9 * (seed + r + 1)) ^ (wa + r);
      for (int s = 24; s >= 0; s -= 8) img.push_back(8'(d >> s));
      expA.push_back((wa + r) & 'hFFFFFF);
      expD.push_back(d);
      expI.push_back(img.size() - 1);
    end
  endtask

  task automatic endImg(bit corrupt);
    int c = crcImg();
    if (corrupt) c = c ^ 1;
    img.push_back(8'(c >> 8)); img.push_back(8'(c));
  endtask

  // bus engine model plus per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    rdValid = 1'b0;
    rdNack  = 1'b0;
    if (rstN) begin
      chk("R11", "slvAddrSel", slvAddrSel, busy ? 0 : addrSelIn);
      chk("R11", "masterMode", masterMode, busy);
      if (wrEn) begin
        if (expA.size() == 0) chk("R3", "unexpected write", 1, 0);
        else begin
          chk("R3", "wrAddr", wrAddr, expA[0]);
          chk("R3", "wrData", wrData, expD[0]);
          void'(expA.pop_front()); void'(expD.pop_front()); void'(expI.pop_front());
        end
      end
      if (rdReq) begin
        if (waitGap) begin
          chk("R10", "request gap", cyc - serveCyc, DIV + 1);
          waitGap = 1'b0;
        end
        if (lat > 0) lat--;
        else begin
          chk("R1", "rdFirst", rdFirst, ptr == 0);
          if (ptr == 0) chk("R1", "rdAddr", rdAddr, 0);
          chk("R9", "rdLast", rdLast, ptr == img.size() - 1);
          if (ptr == nackIdx) rdNack = 1'b1;
          else begin
            rdValid = 1'b1;
            rdData  = (ptr < img.size()) ? img[ptr] : 8'h00;
            ptr++;
          end
          lat = latSet; serveCyc = cyc; waitGap = 1'b1;
        end
      end
    end
  end

  initial forever begin
    @(posedge clk); #2 addrSelIn = ~addrSelIn ^ cyc[3];
  end

  task automatic finishRun(int expBytes, bit expOk, string req);
    int n = 0;
    while (busy && n < 30000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(req, "doneOk", doneOk, expOk);
    chk(req, "doneFail", doneFail, !expOk);
    chk("R9", "bytes read", ptr, expBytes);
    chk("R3", "writes missing", expA.size(), 0);
    waitGap = 1'b0;
  endtask

  task automatic kick();
    ptr = 0; waitGap = 1'b0; lat = latSet;
    @(negedge clk); loadStart = 1'b1;
    @(negedge clk); loadStart = 1'b0;
    chk("R12", "doneOk cleared", doneOk, 0);
    chk("R12", "doneFail cleared", doneFail, 0);
    chk("R12", "busy after start", busy, 1);
  endtask

  initial begin
    // R2 R3 R5: two blocks, good check value, load begins from reset
    newImg(2); addBlk('h40, 3, 1); addBlk('h2000A, 1, 5); endImg(1'b0);
    lat = latSet;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 1);
    chk("R1", "doneOk in reset", doneOk, 0);
    chk("R1", "doneFail in reset", doneFail, 0);
    chk("R1", "rdReq in reset", rdReq, 1);
    chk("R1", "wrEn in reset", wrEn, 0);
    rstN = 1'b1;
    finishRun(img.size(), 1'b1, "R5");
    // R12 sticky while idle
    repeat (40) @(negedge clk);
    chk("R12", "doneOk held", doneOk, 1);
    chk("R11", "idle not master", masterMode, 0);

    // R6: bad check value, writes still made
    latSet = 0;
    newImg(1); addBlk('h3FFFFF, 2, 9); endImg(1'b1);
    kick(); finishRun(img.size(), 1'b0, "R6");
    repeat (20) @(negedge clk);
    chk("R12", "doneFail held", doneFail, 1);

    // R7: same bad image with comparison bypassed
    newImg(1); addBlk('h3FFFFF, 2, 9); endImg(1'b1);
    cfgSkipCrc = 1'b1;
    kick(); finishRun(img.size(), 1'b1, "R7");
    cfgSkipCrc = 1'b0;

    // R4: zero block count
    latSet = 5;
    newImg(0); endImg(1'b0);
    kick(); finishRun(4, 1'b1, "R4");

    // R4: empty blocks around a filled one; R12: start while busy ignored
    newImg(3); addBlk('h10, 0, 0); addBlk('h80, 2, 3); addBlk('h90, 0, 0); endImg(1'b0);
    kick();
    repeat (500) @(negedge clk);
    loadStart = 1'b1; @(negedge clk); loadStart = 1'b0;
    chk("R12", "busy after ignored start", busy, 1);
    finishRun(img.size(), 1'b1, "R4");

    // R8: missing acknowledge inside the second data word
    latSet = 1;
    newImg(2); addBlk('h40, 3, 1); addBlk('h2000A, 1, 5); endImg(1'b0);
    nackIdx = 12;
    while (expI.size() > 0 && expI[expI.size()-1] >= nackIdx) begin
      void'(expA.pop_back()); void'(expD.pop_back()); void'(expI.pop_back());
    end
    kick(); finishRun(nackIdx, 1'b0, "R8");
    repeat (300) @(negedge clk);
    chk("R8", "no request after abort", ptr, nackIdx);
    nackIdx = -1;

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule